// File: doc/BRIEF.md
# I2C SCL Bit-Rate Generator

This block shapes the clock line of an I2C master. From a reference clock it forms a prescaled tick, the reference divided by a power of two chosen by a 3-bit field. It then times an SCL low phase and an SCL high phase, each lasting a programmed count of ticks plus a fixed overhead. The overhead is four ticks when the prescaler is bypassed and three ticks otherwise. This overhead stands for the line synchronizer and noise filter that the real clock path passes through.

The byte engine raises a run request to clock the bus and drops it to idle. While idle, SCL is released and all counters are held cleared. A run request always begins with a low phase. The high phase is not counted until the filtered SCL input is seen high, so a target that holds SCL low stretches the clock. A single-cycle strobe marks the final reference cycle of each completed phase.

Top module: `sclRateGen`

## Requirements
- R1: While `run` is low, `sclDriveLow` is 0, the SCL line is released, and `phaseTick` stays 0.
- R2: On the first clock edge at which `run` is sampled high from idle, `sclDriveLow` goes to 1, so every run starts with a low phase.
- R3: A mode write (`modeWrEn` high) loads the prescale value n from `modeWrData[6:4]` only if `modeWrData[3]` is 1 in the same write. Otherwise the prescale value is unchanged. Reset clears n to 0.
- R4: One prescaled tick is 2^n reference clock cycles, for n from 0 to 7.
- R5: A low phase lasts (lowLen + 4) ticks when n = 0, and (lowLen + 3) ticks when n is not 0.
- R6: The high phase ends 4 reference cycles plus (highLen + overhead) ticks after `sclIn` rises. The 4 cycles are two synchronizer stages, one filter stage and one state step. The overhead is the same one used in R5.
- R7: While `sclIn` is held low after the low phase ends, the block keeps SCL released and does not start the high-phase count.
- R8: `phaseTick` pulses for exactly one cycle, in the last cycle of each completed low or high phase. The SCL drive changes on the following edge.
- R9: `lowLen` and `highLen` must be at least 1 while `run` is high.
- R10: Dropping `run` during any phase returns the block to idle on the next edge, releasing SCL.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| run | input | 1 | Clock the bus (1) or idle (0), from the byte engine |
| modeWrEn | input | 1 | Mode register write strobe |
| modeWrData | input | 8 | Mode write data: prescale in bits 6:4, write release in bit 3 |
| lowLen | input | 5 | Low-phase length in ticks, before overhead |
| highLen | input | 5 | High-phase length in ticks, before overhead |
| sclIn | input | 1 | Observed SCL line level |
| sclDriveLow | output | 1 | 1 pulls SCL low, 0 releases it |
| phaseTick | output | 1 | One-cycle strobe at the end of each phase |

## Verification
A low phase is due exactly T·2^n cycles after the drive is seen asserted. A high phase ends 4 + T·2^n cycles after `sclIn` is first seen high. The bench times both from the first falling-edge sample that shows the new level. The driver pushes these durations into a queue, and the monitor samples only on falling clock edges and compares each finished phase against the queue in order. Stretching is driven from the bench's own open-drain model of the line, so the high-phase timing is always taken from the real rise of `sclIn`. The strobe is checked on the sample just before each drive change.

// File: rtl/sclGenPkg.sv
package sclGenPkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOW,
    ST_WAIT,
    ST_HIGH
  } phaseState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clr;      // clear prescaler and phase counter
    logic cntEn;    // count phase ticks
    logic selHigh;  // use the high-phase length
  } genStrobe_t;
endpackage

// File: rtl/sclGenDatapath.sv
module sclGenDatapath
  import sclGenPkg::*;
#(
  parameter int PsW        = 3,
  parameter int LenW       = 5,
  parameter int ModeW      = 8,
  parameter int PsLsb      = 4,
  parameter int WpBit      = 3,
  parameter int SyncStages = 2,
  parameter int OvhBypass  = 4,
  parameter int OvhDiv     = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  genStrobe_t       strobe,
  input  logic             modeWrEn,
  input  logic [ModeW-1:0] modeWrData,
  input  logic [LenW-1:0]  lowLen,
  input  logic [LenW-1:0]  highLen,
  input  logic             sclIn,
  output logic             phaseDone,
  output logic             sclHigh
);
  localparam int PreW = (1 << PsW) - 1;
  localparam int CntW = LenW + 1;

  logic [PsW-1:0]  psReg;
  logic [PreW-1:0] preCnt, preMax;
  logic [CntW-1:0] phaseCnt, ovh, target;
  logic            tick;

  // prescale field, written only with the release bit set
  always_ff @(posedge clk) begin
    if (!rstN) psReg <= '0;
    else if (modeWrEn && modeWrData[WpBit]) psReg <= modeWrData[PsLsb +: PsW];
  end

  logic unusedModeBits;
  assign unusedModeBits = ^{modeWrData[ModeW-1:PsLsb+PsW], modeWrData[WpBit-1:0]};

  always_comb begin
    preMax = ~({PreW{1'b1}} << psReg);
    tick   = (preCnt >= preMax);
    ovh    = (psReg == '0) ? CntW'(OvhBypass) : CntW'(OvhDiv);
    target = (strobe.selHigh ? {1'b0, highLen} : {1'b0, lowLen}) + ovh;
    phaseDone = strobe.cntEn && tick && (phaseCnt == target - CntW'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clr) preCnt <= '0;
    else if (tick)           preCnt <= '0;
    else                     preCnt <= preCnt + PreW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clr)       phaseCnt <= '0;
    else if (strobe.cntEn && tick) phaseCnt <= phaseCnt + CntW'(1);
  end

  // SCL input synchronizer chain, idle level high
  logic [SyncStages-1:0] syncQ;
  for (genvar i = 0; i < SyncStages; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rstN) syncQ[0] <= 1'b1;
        else       syncQ[0] <= sclIn;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rstN) syncQ[i] <= 1'b1;
        else       syncQ[i] <= syncQ[i-1];
      end
    end
  end

  // one-cycle noise filter: follow only when two stages agree
  always_ff @(posedge clk) begin
    if (!rstN) sclHigh <= 1'b1;
    else if (syncQ[SyncStages-1] == syncQ[SyncStages-2]) sclHigh <= syncQ[SyncStages-1];
  end

  AST_PS_PROTECT: assert property (@(posedge clk) disable iff (!rstN)
    modeWrEn && !modeWrData[WpBit] |=> psReg == $past(psReg)); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    phaseDone |=> !phaseDone); // R8
endmodule

// File: rtl/sclGenControl.sv
module sclGenControl
  import sclGenPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       run,
  input  logic       phaseDone,
  input  logic       sclHigh,
  output genStrobe_t strobe,
  output logic       sclDriveLow
);
  phaseState_t state, nxt;

  always_comb begin
    nxt    = state;
    strobe = '0;
    case (state)
      ST_IDLE: begin
        strobe.clr = 1'b1;
        if (run) nxt = ST_LOW;
      end
      ST_LOW: begin
        strobe.cntEn = 1'b1;
        if (phaseDone) begin
          strobe.clr = 1'b1;
          nxt = ST_WAIT;
        end
      end
      ST_WAIT: begin
        strobe.clr     = 1'b1;
        strobe.selHigh = 1'b1;
        if (sclHigh) nxt = ST_HIGH;
      end
      default: begin
        strobe.cntEn   = 1'b1;
        strobe.selHigh = 1'b1;
        if (phaseDone) begin
          strobe.clr = 1'b1;
          nxt = ST_LOW;
        end
      end
    endcase
    if (!run) begin
      nxt        = ST_IDLE;
      strobe.clr = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  assign sclDriveLow = (state == ST_LOW);

  AST_IDLE_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> !sclDriveLow); // R10

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) && run |=> sclDriveLow); // R2

  AST_STRETCH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT) && !sclHigh && run |=> (state == ST_WAIT) && !sclDriveLow); // R7
endmodule

// File: rtl/sclRateGen.sv
module sclRateGen
  import sclGenPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       run,
  input  logic       modeWrEn,
  input  logic [7:0] modeWrData,
  input  logic [4:0] lowLen,
  input  logic [4:0] highLen,
  input  logic       sclIn,
  output logic       sclDriveLow,
  output logic       phaseTick
);
  genStrobe_t strobe;
  logic       phaseDone, sclHigh;

  sclGenControl ctl_i (
    .clk         (clk),
    .rstN        (rstN),
    .run         (run),
    .phaseDone   (phaseDone),
    .sclHigh     (sclHigh),
    .strobe      (strobe),
    .sclDriveLow (sclDriveLow)
  );

  sclGenDatapath #(
    .PsW  (3),
    .LenW (5),
    .ModeW(8)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .modeWrEn   (modeWrEn),
    .modeWrData (modeWrData),
    .lowLen     (lowLen),
    .highLen    (highLen),
    .sclIn      (sclIn),
    .phaseDone  (phaseDone),
    .sclHigh    (sclHigh)
  );

  assign phaseTick = phaseDone;

  AST_MIN_LEN: assert property (@(posedge clk) disable iff (!rstN)
    run |-> (lowLen != 5'd0) && (highLen != 5'd0)); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> !phaseTick); // R1
endmodule

// File: tb/sclRateGen_tb_top.sv
module sclRateGen_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       run = 1'b0;
  logic       modeWrEn = 1'b0;
  logic [7:0] modeWrData = '0;
  logic [4:0] lowLen = 5'd1;
  logic [4:0] highLen = 5'd1;
  logic       sclIn;
  logic       sclDriveLow, phaseTick;

  int stretchK = 0;
  int stretchCnt = 0;

  always #4 clk = ~clk;

  // open-drain line: the target may hold SCL low after the master releases it
  always @(posedge clk) begin
    if (sclDriveLow) stretchCnt <= stretchK;
    else if (stretchCnt != 0) stretchCnt <= stretchCnt - 1;
  end
  assign sclIn = !sclDriveLow && (stretchCnt == 0);

  sclRateGen dut_i (
    .clk(clk), .rstN(rstN), .run(run), .modeWrEn(modeWrEn), .modeWrData(modeWrData),
    .lowLen(lowLen), .highLen(highLen), .sclIn(sclIn),
    .sclDriveLow(sclDriveLow), .phaseTick(phaseTick)
  );

  typedef struct {
    bit    isLow;
    int    cycles;
    string req;
  } expItem_t;
  expItem_t expQ[$];

  int nCmp = 0, nBad = 0;
  int modelPs = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  // monitor: measures finished phases and compares them in order
  bit inSeen = 0, prevTick = 0, prevLow = 0;
  int lowCnt = 0, hiCnt = 0;

  task automatic record(input bit isLow, input int cyc);
    expItem_t e;
    if (expQ.size() == 0) return;
    e = expQ.pop_front();
    chk(e.isLow == isLow, e.req, int'(isLow), int'(e.isLow));
    chk(e.cycles == cyc, e.req, cyc, e.cycles);
  endtask

  always @(negedge clk) begin
    if (!rstN || !run) begin
      inSeen = 0; lowCnt = 0; hiCnt = 0;
    end else begin
      if (inSeen && (sclDriveLow != prevLow)) chk(prevTick, "R8", int'(prevTick), 1);
      if (inSeen && prevTick) chk(sclDriveLow != prevLow, "R8", int'(sclDriveLow), int'(!prevLow));
      if (sclDriveLow) begin
        if (hiCnt > 0) record(1'b0, hiCnt);
        hiCnt = 0;
        lowCnt++;
        inSeen = 1;
      end else begin
        if (lowCnt > 0) begin
          record(1'b1, lowCnt);
          lowCnt = 0;
        end
        if (inSeen && sclIn) hiCnt++;
      end
    end
    prevTick = phaseTick;
    prevLow  = sclDriveLow;
  end

  task automatic writeMode(input logic [7:0] d);
    @(negedge clk);
    modeWrEn = 1'b1;
    modeWrData = d;
    if (d[3]) modelPs = int'(d[6:4]);
    @(negedge clk);
    modeWrEn = 1'b0;
  endtask

  // driver: sets up one configuration, pushes the expected phases, runs the bus
  task automatic runCfg(input int lo, input int hi, input int k,
                        input string loReq, input string hiReq, input bit chkStart);
    int ovh, scale;
    expItem_t e;
    ovh   = (modelPs == 0) ? 4 : 3;
    scale = 1 << modelPs;
    lowLen = 5'(lo);
    highLen = 5'(hi);
    stretchK = k;
    for (int i = 0; i < 3; i++) begin
      e.isLow = 1; e.cycles = (lo + ovh) * scale; e.req = loReq;
      expQ.push_back(e);
      e.isLow = 0; e.cycles = 4 + (hi + ovh) * scale; e.req = hiReq;
      expQ.push_back(e);
    end
    @(negedge clk);
    run = 1'b1;
    @(negedge clk);
    if (chkStart) chk(sclDriveLow == 1'b1, "R2", int'(sclDriveLow), 1);
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
    run = 1'b0;
    repeat (3) @(negedge clk);
    chk(sclDriveLow == 1'b0, "R10", int'(sclDriveLow), 0);
    chk(phaseTick == 1'b0, "R1", int'(phaseTick), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(sclDriveLow == 1'b0, "R1", int'(sclDriveLow), 0);
    chk(phaseTick == 1'b0, "R1", int'(phaseTick), 0);
    repeat (5) @(negedge clk);
    chk(sclDriveLow == 1'b0, "R1", int'(sclDriveLow), 0);

    runCfg(1, 1, 0, "R5 bypass low", "R6 bypass high", 1'b1);
    runCfg(31, 31, 0, "R5 max low", "R6 max high", 1'b1);
    writeMode(8'b0001_1000);
    runCfg(2, 5, 0, "R4 div2 low", "R6 div2 high", 1'b0);
    writeMode(8'b0011_1000);
    runCfg(4, 1, 7, "R5 div8 low", "R7 stretched high", 1'b0);
    writeMode(8'b0101_0000);
    runCfg(3, 2, 0, "R3 protected low", "R3 protected high", 1'b0);
    writeMode(8'b0111_1000);
    runCfg(1, 1, 0, "R4 div128 low", "R6 div128 high", 1'b0);
    writeMode(8'b0000_1000);
    runCfg(6, 9, 20, "R5 back to bypass", "R7 long stretch", 1'b1);
    finish();
  end
endmodule